// File: doc/BRIEF.md
# Serial Clock Burst Generator

This block drives the serial clock of a synchronous serial master port. It divides the system clock by 2, 4, 8 or 16. A host access to the port's status or data register triggers one burst of exactly eight serial clock cycles. Between bursts the clock line is held high. An attached shift register is paced by two one-cycle strobes: one marks each falling edge, where data is launched, and one marks each rising edge, where data is sampled.

The divide select comes from a two-bit control field. The block captures it when a burst starts. A change to the field while a burst runs therefore takes effect only on the next burst. A trigger that arrives while a burst is running is dropped. A separate enable lets the pad driver place the clock in its high-impedance state during reset.

Top module: `sclk_burst_gen`

## Requirements
- R1: While reset is asserted (`rst_n` low), the outputs are `sclk_o`=1, `busy`=0, `launch_stb`=0, `sample_stb`=0 and `sclk_oe`=0. This holds even when reset arrives in the middle of a burst.
- R2: `sclk_oe` reads 1 from the first rising clock edge after reset is released.
- R3: With no trigger, the block is idle: `sclk_o` stays 1, `busy` stays 0, and neither strobe pulses.
- R4: When `trig` is high at a clock edge while `busy` is low, the outputs after that edge are `busy`=1, `sclk_o`=0 and `launch_stb`=1.
- R5: Each half period of `sclk_o` lasts 2^`div_sel` system clocks. The field encodes 00 = divide by 2, 01 = divide by 4, 10 = divide by 8 and 11 = divide by 16.
- R6: Each burst gives exactly 8 `launch_stb` pulses, each one system clock long and coinciding with a falling edge of `sclk_o`. It also gives exactly 8 `sample_stb` pulses, each coinciding with a rising edge of `sclk_o`.
- R7: `busy` falls in the same cycle as the eighth rising edge, which comes 15 half periods after the burst starts. `sclk_o` then stays high.
- R8: `div_sel` is captured at burst start. Changes to it during a burst do not alter that burst.
- R9: A `trig` that arrives while `busy` is high is ignored. The running burst is unchanged and no further burst follows.
- R10: A `trig` applied in the cycle where `busy` has just fallen starts a new burst immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Divide select (00 = /2, 01 = /4, 10 = /8, 11 = /16) |
| trig | input | 1 | Register-access strobe that requests a burst |
| sclk_o | output | 1 | Serial clock pin value, high at rest |
| sclk_oe | output | 1 | Output enable for the serial clock pad |
| busy | output | 1 | High while a burst is in progress |
| launch_stb | output | 1 | One-cycle pulse on each falling edge of `sclk_o` |
| sample_stb | output | 1 | One-cycle pulse on each rising edge of `sclk_o` |

## Verification
Every output is registered, so a wrong phase count or a wrong captured select shows up within one half period as a misplaced `sclk_o` edge or strobe. A bad edge counter shows up at the end of the burst, as `busy` falling at the wrong cycle or as a launch or sample total other than eight. The bench compares the whole output vector against a computed waveform on every cycle of every burst. A single stray or missing edge is therefore caught in the cycle where it occurs, not only in the final totals.

// File: rtl/sclk_burst_gen.sv
module sclk_burst_gen #(
  parameter int NUM_BITS = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             trig,
  output logic             sclk_o,
  output logic             sclk_oe,
  output logic             busy,
  output logic             launch_stb,
  output logic             sample_stb
);
  localparam int PH_W  = (1 << SEL_W) - 1;
  localparam int CNT_W = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(NUM_BITS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] edges;
  logic [PH_W-1:0]  half_last;
  logic             half_done;

  assign half_last = PH_W'((32'd1 << sel_q) - 32'd1);
  assign half_done = (phase == half_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_o     <= 1'b1;
      sclk_oe    <= 1'b0;
      busy       <= 1'b0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
      sel_q      <= '0;
      phase      <= '0;
      edges      <= '0;
    end else begin
      sclk_oe    <= 1'b1;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
      if (!busy) begin
        if (trig) begin
          busy       <= 1'b1;
          sel_q      <= div_sel;
          sclk_o     <= 1'b0;
          launch_stb <= 1'b1;
          phase      <= '0;
          edges      <= '0;
        end
      end else if (half_done) begin
        phase  <= '0;
        sclk_o <= ~sclk_o;
        if (sclk_o) begin
          launch_stb <= 1'b1;
        end else begin
          sample_stb <= 1'b1;
          edges      <= edges + 1'b1;
          if (edges == LAST_EDGE) busy <= 1'b0;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

module sclk_burst_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic sclk_o,
  input logic sclk_oe,
  input logic busy,
  input logic launch_stb,
  input logic sample_stb
);
  // R6
  launch_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> (!sclk_o && $past(sclk_o)));
  // R6
  sample_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sclk_o && !$past(sclk_o)));
  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o && !launch_stb));
  // R4
  start_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy) |=> (busy && launch_stb && !sclk_o));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_stb && sample_stb));
  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |=> sclk_oe);
  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sample_stb && sclk_o));
endmodule

bind sclk_burst_gen sclk_burst_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
  .busy(busy), .launch_stb(launch_stb), .sample_stb(sample_stb)
);

// File: tb/tb_sclk_burst_gen.sv
`timescale 1ns/1ps
module tb_sclk_burst_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       trig = 1'b0;
  logic       sclk_o, sclk_oe, busy, launch_stb, sample_stb;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sclk_burst_gen dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .trig(trig),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .busy(busy),
    .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  // {select, half period, cycles to eighth rise}
  localparam int VEC [4][3] = '{'{0, 1, 15}, '{1, 2, 30}, '{2, 4, 60}, '{3, 8, 120}};

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expect_vec(input int k, input int h, input int len);
    if (k < len) return {((k / h) % 2 == 1), 1'b1, (k % (2*h) == 0), (k % (2*h) == h)};
    if (k == len) return 4'b1001;
    return 4'b1000;
  endfunction

  // start: drive trig now; disturb: change select and retrigger mid-burst; chain: stop at the eighth rise
  task automatic burst(input int sel, input int h, input int len, input bit disturb,
                       input bit chain, input string req);
    int launches = 0;
    int samples  = 0;
    int last_k   = chain ? len : len + 3;
    div_sel = 2'(sel);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int k = 0; k <= last_k; k++) begin
      if (k > 0) @(negedge clk);
      check(req, int'({sclk_o, busy, launch_stb, sample_stb}), int'(expect_vec(k, h, len)));
      launches += int'(launch_stb);
      samples  += int'(sample_stb);
      if (disturb && k == 2) begin
        div_sel = ~2'(sel);
        trig = 1'b1;
      end
      if (disturb && k == 3) trig = 1'b0;
    end
    check({req, " R6 launches"}, launches, 8);
    check({req, " R6 samples"}, samples, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'({sclk_o, busy, launch_stb, sample_stb, sclk_oe}), 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", int'(sclk_oe), 1);
    // R3 idle with no trigger
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R3", int'({sclk_o, busy, launch_stb, sample_stb}), 4'b1000);
    end
    // R4 R5 R6 R7 table of ratios
    for (int v = 0; v < 4; v++)
      burst(VEC[v][0], VEC[v][1], VEC[v][2], 1'b0, 1'b0, "R5");
    // R8 R9 select change and retrigger during burst
    burst(1, 2, 30, 1'b1, 1'b0, "R8/R9");
    burst(0, 1, 15, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R9 no extra burst", int'({sclk_o, busy}), 2'b10);
    end
    // R10 back-to-back
    burst(0, 1, 15, 1'b0, 1'b1, "R7");
    burst(2, 4, 60, 1'b0, 1'b0, "R10");
    // R1 reset during a burst
    div_sel = 2'b01;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid-burst", int'({sclk_o, busy, launch_stb, sample_stb, sclk_oe}), 5'b10000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after reset", int'({sclk_oe, sclk_o, busy}), 3'b110);
    burst(3, 8, 120, 1'b0, 1'b0, "R4");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule